// File: doc/BRIEF.md
# Descriptor Command Sequencer

This block is the per-channel engine of a descriptor-driven DMA controller. While the channel is both running and active, it reads a 16-byte descriptor from memory at the current descriptor pointer and decodes its command. It then does one of four things: it starts an input or output transfer on a stream handshake, it performs a single load-word or store-word access of 1, 2 or 4 bytes, it treats the descriptor as a no-op, or it stops the channel.

When the command completes, the sequencer writes the channel status and a residual count back into the descriptor. It then hands control to the next stage, which either evaluates a conditional branch or simply advances to the next descriptor. A malformed command kills the channel.

The register file, the stream data path and the branch/interrupt stage sit outside this block. They see the sequencer only through single-cycle pulses: wake clear, kill, stop, flush clear and done.

Top module: `dsq_top`

## Requirements
- R1: After reset the block issues no memory request and no transfer request, and all of `wake_clr`, `kill_pulse`, `stop_pulse`, `flush_clr` and `done_valid` are low.
- R2: A fetch starts only while `chan_run` and `chan_active` are both high. The fetch issues four 32-bit reads, one at a time, at the pointer (with its low 4 bits cleared) plus 0, 4, 8 and 12. Word 0 holds the request count in bits 15:0 and the command in bits 31:16. Word 1 holds the address. Word 2 holds the dependency word. Word 3 holds the residual in bits 15:0 and the status in bits 31:16. A request is held, unchanged, until `mem_req_ready`.
- R3: `wake_clr` pulses exactly once per descriptor, in the cycle that the command is decoded.
- R4: Opcode 7 (the command's bits 15:12) pulses `stop_pulse`, then performs no write-back and no handoff.
- R5: `kill_pulse` fires in the decode cycle, with no write-back and no handoff, in any of these cases:
  - key 4 (the command's bits 10:8) on any command other than opcode 6 or 7;
  - opcode 8 to 15;
  - a transfer whose address is 0 or whose key is above 3.
- R6: Opcodes 0 to 3 are transfers. Bit 1 of the opcode set means input; bit 0 set means last. For a transfer, `xfer_valid` is raised with the descriptor's address, request count, key, direction and last flag, and held until `xfer_ready`. The block then waits for `xfer_done` and takes `xfer_resid` as the residual.
- R7: On completion the block writes word 2 (the dependency word) and then word 3, which is `{chan_status, residual}`. For a transfer the residual is the returned value; for a no-op or a load/store it is the fetched residual.
- R8: `flush_clr` pulses with the handoff after a last transfer or a load/store, and not after a more-transfer or a no-op.
- R9: For opcode 4 (store) and opcode 5 (load), only request count bits 2:0 count. If bit 2 is set, the size is 4 bytes and the address is aligned to 4. Otherwise, if bit 1 is set, the size is 2 bytes and the address is aligned to 2. Otherwise the size is 1 byte.
- R10: A store writes the most significant bytes of the dependency word, little-endian, at the normalized address, using byte enables.
- R11: A 4-byte load replaces the dependency word. A 2-byte or 1-byte load places its data in the top bytes of the dependency word and keeps the lower bytes.
- R12: A load/store with key 0 to 3 is treated as the system key (6). With key 6 it proceeds. With key 5 or 7 it kills the channel.
- R13: The handoff is a single-cycle `done_valid` carrying `done_dep`. `done_branch` is 1 for a no-op or a transfer, and 0 for a load/store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chan_run | input | 1 | Channel run flag |
| chan_active | input | 1 | Channel active flag |
| desc_ptr | input | ADDR_W | Current descriptor pointer |
| chan_status | input | 16 | Channel status written into descriptor |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_we | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | ADDR_W | Word-aligned byte address |
| mem_req_be | output | 4 | Byte enables |
| mem_req_wdata | output | 32 | Write data |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Read data |
| xfer_valid | output | 1 | Transfer start request |
| xfer_ready | input | 1 | Transfer start accepted |
| xfer_out | output | 1 | 1 = memory to device |
| xfer_last | output | 1 | Last-segment transfer |
| xfer_key | output | 3 | Stream key |
| xfer_addr | output | ADDR_W | Transfer buffer address |
| xfer_len | output | 16 | Requested byte count |
| xfer_done | input | 1 | Transfer finished |
| xfer_resid | input | 16 | Residual count at finish |
| wake_clr | output | 1 | Clear wake flag (command start) |
| kill_pulse | output | 1 | Mark channel dead, clear active |
| stop_pulse | output | 1 | Clear active, dead and flush |
| flush_clr | output | 1 | Clear flush flag |
| done_valid | output | 1 | Handoff to branch stage |
| done_branch | output | 1 | 1 = evaluate branch, 0 = advance |
| done_dep | output | 32 | Dependency word at handoff |

## Verification
Two pairs of functions share a single cycle.

The first pair is the command-start wake clear and a kill. Every kill is resolved in the decode cycle, which is the same cycle that clears wake. The bench provokes this with key 4, a null transfer address and bad load/store keys. It then requires that the kill pulse was seen in the same sampled cycle as the wake pulse, and that wake fired exactly once.

The second pair is the flush clear and the handoff. The bench runs last transfers and loads/stores next to more-transfers and no-ops. It counts flush pulses against handoffs, and it checks that the write-back words in its memory model already hold the expected status and residual when the handoff is seen.

// File: rtl/dsq_pkg.sv
package dsq_pkg;
   localparam logic [2:0] KEY_LAST_STREAM = 3'd3;
   localparam logic [2:0] KEY_FORBIDDEN   = 3'd4;
   localparam logic [2:0] KEY_REGS        = 3'd5;
   localparam logic [2:0] KEY_SYSTEM      = 3'd6;

   localparam logic [3:0] OP_STORE = 4'd4;
   localparam logic [3:0] OP_LOAD  = 4'd5;
   localparam logic [3:0] OP_NOP   = 4'd6;
   localparam logic [3:0] OP_STOP  = 4'd7;

   typedef enum logic [2:0] {
      ACT_KILL, ACT_STOP, ACT_NOP, ACT_XFER, ACT_LOAD, ACT_STORE
   } act_e;

   typedef enum logic [3:0] {
      S_IDLE, S_FREQ, S_FRSP, S_DEC, S_XREQ, S_XWAIT,
      S_LREQ, S_LRSP, S_WB2, S_WB3, S_HAND
   } seq_state_e;
endpackage

// File: rtl/dsq_cmd_decode.sv
module dsq_cmd_decode
   import dsq_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  logic [3:0]        op,
   input  logic [2:0]        key,
   input  logic [ADDR_W-1:0] addr,
   output act_e              act
);
   logic [2:0] word_key;

   always_comb begin
      // low keys on word accesses fall back to the system key
      word_key = (key < KEY_REGS) ? KEY_SYSTEM : key;
      if (op == OP_STOP)
         act = ACT_STOP;
      else if (op == OP_NOP)
         act = ACT_NOP;
      else if (key == KEY_FORBIDDEN || op[3])
         act = ACT_KILL;
      else if (op < OP_STORE)
         act = (addr == '0 || key > KEY_LAST_STREAM) ? ACT_KILL : ACT_XFER;
      else if (word_key != KEY_SYSTEM)
         act = ACT_KILL;
      else
         act = (op == OP_LOAD) ? ACT_LOAD : ACT_STORE;
   end
endmodule

// File: rtl/dsq_word_lanes.sv
module dsq_word_lanes #(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32
) (
   input  logic [2:0]        req_low,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] dep,
   input  logic [DATA_W-1:0] rdata,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [DATA_W/8-1:0] be,
   output logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] dep_loaded,
   output logic [2:0]        size
);
   localparam int LANES = DATA_W / 8;

   if (DATA_W != 32) begin : g_bad_width
      $error("dsq_word_lanes: DATA_W must be 32");
   end

   logic       sz4, sz2;
   logic [1:0] ofs;
   logic [15:0] half;
   logic [7:0]  byt;

   assign sz4  = req_low[2];
   assign sz2  = !req_low[2] && req_low[1];
   assign ofs  = addr[1:0];
   assign size = sz4 ? 3'd4 : (sz2 ? 3'd2 : 3'd1);
   assign bus_addr = {addr[ADDR_W-1:2], 2'b00};

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      localparam logic [1:0] LI = 2'(i);
      assign be[i] = sz4 || (sz2 && LI[1] == ofs[1]) || (!sz4 && !sz2 && LI == ofs);
      assign wdata[8*i +: 8] = sz4 ? dep[8*i +: 8]
                             : (sz2 ? dep[16 + 8*(i % 2) +: 8] : dep[31:24]);
   end

   assign half = ofs[1] ? rdata[31:16] : rdata[15:0];
   assign byt  = 8'(rdata >> {ofs, 3'b000});
   assign dep_loaded = sz4 ? rdata : (sz2 ? {half, dep[15:0]} : {byt, dep[23:0]});

   always_comb begin
      p_lane_count_r9: assert ($countones(be) == 32'(size))
         else $error("byte enables do not match normalized size");
   end
endmodule

// File: rtl/dsq_top.sv
module dsq_top
   import dsq_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int CNT_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              chan_run,
   input  logic              chan_active,
   input  logic [ADDR_W-1:0] desc_ptr,
   input  logic [15:0]       chan_status,
   output logic              mem_req_valid,
   input  logic              mem_req_ready,
   output logic              mem_req_we,
   output logic [ADDR_W-1:0] mem_req_addr,
   output logic [3:0]        mem_req_be,
   output logic [31:0]       mem_req_wdata,
   input  logic              mem_rsp_valid,
   input  logic [31:0]       mem_rsp_data,
   output logic              xfer_valid,
   input  logic              xfer_ready,
   output logic              xfer_out,
   output logic              xfer_last,
   output logic [2:0]        xfer_key,
   output logic [ADDR_W-1:0] xfer_addr,
   output logic [CNT_W-1:0]  xfer_len,
   input  logic              xfer_done,
   input  logic [CNT_W-1:0]  xfer_resid,
   output logic              wake_clr,
   output logic              kill_pulse,
   output logic              stop_pulse,
   output logic              flush_clr,
   output logic              done_valid,
   output logic              done_branch,
   output logic [31:0]       done_dep
);
   localparam int DESC_WORDS = 4;
   localparam int IDX_W      = $clog2(DESC_WORDS);
   localparam logic [ADDR_W-1:0] PTR_MASK = {{(ADDR_W-4){1'b1}}, 4'h0};

   if (CNT_W != 16) begin : g_bad_cnt
      $error("dsq_top: CNT_W must be 16 to fit the descriptor");
   end
   if (ADDR_W > 32 || ADDR_W < 8) begin : g_bad_addr
      $error("dsq_top: ADDR_W out of range");
   end

   seq_state_e        st;
   logic [ADDR_W-1:0] ptr_q, addr_q;
   logic [IDX_W-1:0]  idx_q;
   logic [3:0]        op_q;
   logic [2:0]        key_q;
   logic [CNT_W-1:0]  req_q, resid_q;
   logic [31:0]       dep_q;
   logic              br_q, fl_q, store_q;
   act_e              act;
   logic [ADDR_W-1:0] ln_addr;
   logic [3:0]        ln_be;
   logic [31:0]       ln_wdata, ln_dep;
   logic [2:0]        ln_size;

   dsq_cmd_decode #(.ADDR_W(ADDR_W)) u_dec (
      .op(op_q), .key(key_q), .addr(addr_q), .act(act)
   );

   dsq_word_lanes #(.ADDR_W(ADDR_W), .DATA_W(32)) u_lanes (
      .req_low(req_q[2:0]), .addr(addr_q), .dep(dep_q), .rdata(mem_rsp_data),
      .bus_addr(ln_addr), .be(ln_be), .wdata(ln_wdata), .dep_loaded(ln_dep),
      .size(ln_size)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= S_IDLE;  ptr_q <= '0;  addr_q <= '0;  idx_q <= '0;
         op_q <= '0;  key_q <= '0;  req_q <= '0;  resid_q <= '0;
         dep_q <= '0;  br_q <= 1'b0;  fl_q <= 1'b0;  store_q <= 1'b0;
      end else begin
         unique case (st)
            S_IDLE: if (chan_run && chan_active) begin
               ptr_q <= desc_ptr & PTR_MASK;
               idx_q <= '0;
               st    <= S_FREQ;
            end
            S_FREQ: if (mem_req_ready) st <= S_FRSP;
            S_FRSP: if (mem_rsp_valid) begin
               unique case (idx_q)
                  2'd0: begin
                     op_q  <= mem_rsp_data[31:28];
                     key_q <= mem_rsp_data[26:24];
                     req_q <= mem_rsp_data[15:0];
                  end
                  2'd1: addr_q  <= mem_rsp_data[ADDR_W-1:0];
                  2'd2: dep_q   <= mem_rsp_data;
                  default: resid_q <= mem_rsp_data[15:0];
               endcase
               idx_q <= idx_q + 1'b1;
               st    <= (idx_q == IDX_W'(DESC_WORDS-1)) ? S_DEC : S_FREQ;
            end
            S_DEC: begin
               store_q <= (act == ACT_STORE);
               unique case (act)
                  ACT_NOP:  begin br_q <= 1'b1; fl_q <= 1'b0;    st <= S_WB2;  end
                  ACT_XFER: begin br_q <= 1'b1; fl_q <= op_q[0]; st <= S_XREQ; end
                  ACT_LOAD, ACT_STORE: begin br_q <= 1'b0; fl_q <= 1'b1; st <= S_LREQ; end
                  default:  st <= S_IDLE;
               endcase
            end
            S_XREQ: if (xfer_ready) st <= S_XWAIT;
            S_XWAIT: if (xfer_done) begin
               resid_q <= xfer_resid;
               st      <= S_WB2;
            end
            S_LREQ: if (mem_req_ready) st <= store_q ? S_WB2 : S_LRSP;
            S_LRSP: if (mem_rsp_valid) begin
               dep_q <= ln_dep;
               st    <= S_WB2;
            end
            S_WB2: if (mem_req_ready) st <= S_WB3;
            S_WB3: if (mem_req_ready) st <= S_HAND;
            default: st <= S_IDLE;
         endcase
      end
   end

   always_comb begin
      mem_req_valid = 1'b0;
      mem_req_we    = 1'b0;
      mem_req_addr  = ptr_q + (ADDR_W'(idx_q) << 2);
      mem_req_be    = 4'hF;
      mem_req_wdata = dep_q;
      unique case (st)
         S_FREQ: mem_req_valid = 1'b1;
         S_LREQ: begin
            mem_req_valid = 1'b1;
            mem_req_we    = store_q;
            mem_req_addr  = ln_addr;
            mem_req_be    = ln_be;
            mem_req_wdata = ln_wdata;
         end
         S_WB2: begin
            mem_req_valid = 1'b1;
            mem_req_we    = 1'b1;
            mem_req_addr  = ptr_q + ADDR_W'(8);
         end
         S_WB3: begin
            mem_req_valid = 1'b1;
            mem_req_we    = 1'b1;
            mem_req_addr  = ptr_q + ADDR_W'(12);
            mem_req_wdata = {chan_status, resid_q};
         end
         default: ;
      endcase
   end

   assign xfer_valid  = (st == S_XREQ);
   assign xfer_out    = !op_q[1];
   assign xfer_last   = op_q[0];
   assign xfer_key    = key_q;
   assign xfer_addr   = addr_q;
   assign xfer_len    = req_q;
   assign wake_clr    = (st == S_DEC);
   assign kill_pulse  = (st == S_DEC) && (act == ACT_KILL);
   assign stop_pulse  = (st == S_DEC) && (act == ACT_STOP);
   assign done_valid  = (st == S_HAND);
   assign done_branch = br_q;
   assign done_dep    = dep_q;
   assign flush_clr   = (st == S_HAND) && fl_q;

   p_req_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_we));
   p_wake_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(xfer_valid) |-> $past(wake_clr));
   p_stop_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
      stop_pulse |=> !mem_req_valid && !done_valid);
   p_kill_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
      kill_pulse |=> !mem_req_valid && !xfer_valid && !done_valid);
   p_xfer_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_valid && !xfer_ready |=> xfer_valid && $stable(xfer_addr) && $stable(xfer_len));
   p_wb_before_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done_valid |-> $past(mem_req_valid && mem_req_we && mem_req_ready));
   p_flush_with_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
      flush_clr |-> done_valid);
   p_done_pulse_r13: assert property (@(posedge clk) disable iff (!rst_n)
      done_valid |=> !done_valid);
endmodule

// File: tb/sim_dsq_top.sv
module sim_dsq_top;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic chan_run = 1'b0, chan_active = 1'b0;
   logic [31:0] desc_ptr = 32'h100;
   logic [15:0] chan_status = 16'hA5C3;
   logic mem_req_valid, mem_req_ready = 1'b0, mem_req_we;
   logic [31:0] mem_req_addr, mem_req_wdata;
   logic [3:0]  mem_req_be;
   logic mem_rsp_valid = 1'b0;
   logic [31:0] mem_rsp_data = '0;
   logic xfer_valid, xfer_ready = 1'b0, xfer_out, xfer_last, xfer_done = 1'b0;
   logic [2:0]  xfer_key;
   logic [31:0] xfer_addr;
   logic [15:0] xfer_len, xfer_resid = '0;
   logic wake_clr, kill_pulse, stop_pulse, flush_clr, done_valid, done_branch;
   logic [31:0] done_dep;

   always #10 clk = ~clk;

   dsq_top u0 (.*);

   logic [31:0] mem [256];
   int cyc = 0, n_cmp = 0, n_bad = 0;
   bit rd_pend = 0;
   logic [31:0] rd_word;
   int cd = 0;
   int n_wake, n_kill, n_stop, n_done, n_flush, n_fetch;
   bit kill_wake, d_br, x_out, x_last;
   logic [31:0] d_dep, first_addr, x_addr;
   logic [15:0] x_len;
   logic [2:0]  x_key;
   bit any_req;

   // memory, stream responder and monitor in one negedge process
   always @(negedge clk) begin
      cyc++;
      mem_rsp_valid = 1'b0;
      if (rd_pend) begin mem_rsp_valid = 1'b1; mem_rsp_data = rd_word; rd_pend = 0; end
      mem_req_ready = (cyc % 3) != 1;
      if (mem_req_valid) any_req = 1;
      if (mem_req_valid && mem_req_ready) begin
         if (mem_req_we) begin
            for (int b = 0; b < 4; b++)
               if (mem_req_be[b]) mem[mem_req_addr[9:2]][8*b +: 8] = mem_req_wdata[8*b +: 8];
         end else begin
            rd_pend = 1; rd_word = mem[mem_req_addr[9:2]];
            if (n_wake == 0) begin
               if (n_fetch == 0) first_addr = mem_req_addr;
               n_fetch++;
            end
         end
      end
      xfer_done = 1'b0;
      if (cd == 1) begin xfer_done = 1'b1; xfer_resid = x_len >> 1; cd = 0; end
      else if (cd > 1) cd--;
      xfer_ready = (cyc % 4) != 2;
      if (xfer_valid && xfer_ready) begin
         cd = 3; x_addr = xfer_addr; x_len = xfer_len; x_out = xfer_out;
         x_last = xfer_last; x_key = xfer_key;
      end
      if (wake_clr) begin n_wake++; if (kill_pulse) kill_wake = 1; end
      if (kill_pulse) n_kill++;
      if (stop_pulse) n_stop++;
      if (flush_clr) n_flush++;
      if (done_valid) begin n_done++; d_br = done_branch; d_dep = done_dep; end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", tag, act, exp);
      end
   endtask

   task automatic clear_mon();
      n_wake = 0; n_kill = 0; n_stop = 0; n_done = 0; n_flush = 0; n_fetch = 0;
      kill_wake = 0; d_br = 0; d_dep = '0; first_addr = '0; any_req = 0;
   endtask

   task automatic run_one(input logic [31:0] w0, w1, w2);
      bit fin = 0;
      mem[8'h40] = w0; mem[8'h41] = w1; mem[8'h42] = w2; mem[8'h43] = 32'h0000_7777;
      clear_mon();
      @(negedge clk); #1;
      chan_run = 1'b1; chan_active = 1'b1;
      for (int t = 0; t < 500 && !fin; t++) begin
         @(negedge clk); #1;
         if (n_done + n_kill + n_stop != 0) fin = 1;
      end
      chan_run = 1'b0; chan_active = 1'b0;
      if (!fin) chk("R13 descriptor never finished", 32'd0, 32'd1);
      repeat (4) @(negedge clk);
      #1;
   endtask

   // w0, w1, w2, outcome(0 branch,1 next,2 kill,3 stop), flush, word2 after, word3 after
   localparam logic [167:0] VECS [14] = '{
      {32'h0000_0040, 32'h200, 32'h1234_5678, 4'h0, 4'h0, 32'h1234_5678, 32'hA5C3_0020},
      {32'h3300_0020, 32'h200, 32'h1234_5678, 4'h0, 4'h1, 32'h1234_5678, 32'hA5C3_0010},
      {32'h6000_0000, 32'h000, 32'h1234_5678, 4'h0, 4'h0, 32'h1234_5678, 32'hA5C3_7777},
      {32'h7000_0000, 32'h000, 32'h1234_5678, 4'h3, 4'h0, 32'h1234_5678, 32'h0000_7777},
      {32'h0400_0040, 32'h200, 32'h1234_5678, 4'h2, 4'h0, 32'h1234_5678, 32'h0000_7777},
      {32'h2000_0010, 32'h000, 32'h1234_5678, 4'h2, 4'h0, 32'h1234_5678, 32'h0000_7777},
      {32'h1600_0010, 32'h200, 32'h1234_5678, 4'h2, 4'h0, 32'h1234_5678, 32'h0000_7777},
      {32'h5600_0004, 32'h203, 32'h1111_2222, 4'h1, 4'h1, 32'hCAFE_F00D, 32'hA5C3_7777},
      {32'h5000_0003, 32'h203, 32'h1111_2222, 4'h1, 4'h1, 32'hCAFE_2222, 32'hA5C3_7777},
      {32'h5600_0000, 32'h201, 32'h1111_2222, 4'h1, 4'h1, 32'hF011_2222, 32'hA5C3_7777},
      {32'h4500_0001, 32'h210, 32'h1111_2222, 4'h2, 4'h0, 32'h1111_2222, 32'h0000_7777},
      {32'h5700_0004, 32'h200, 32'h1111_2222, 4'h2, 4'h0, 32'h1111_2222, 32'h0000_7777},
      {32'h5600_0006, 32'h202, 32'h1111_2222, 4'h1, 4'h1, 32'hCAFE_F00D, 32'hA5C3_7777},
      {32'h5600_0002, 32'h201, 32'h1111_2222, 4'h1, 4'h1, 32'hF00D_2222, 32'hA5C3_7777}
   };

   initial begin
      #(20 * 150000);
      chk("watchdog expired", 32'd0, 32'd1);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      for (int i = 0; i < 256; i++) mem[i] = '0;
      mem[8'h80] = 32'hCAFE_F00D;
      clear_mon();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      #1;
      // R1: quiet after reset
      chk("R1 reset outputs", {27'd0, mem_req_valid, xfer_valid, done_valid, kill_pulse, wake_clr},
          32'd0);
      chk("R1 reset pulses", {30'd0, stop_pulse, flush_clr}, 32'd0);
      // R2: no fetch unless both run and active
      chan_run = 1'b1; chan_active = 1'b0;
      repeat (8) @(negedge clk);
      chan_run = 1'b0; chan_active = 1'b1;
      repeat (8) @(negedge clk);
      #1;
      chan_active = 1'b0;
      chk("R2 gated fetch", {31'd0, any_req}, 32'd0);

      for (int v = 0; v < 14; v++) begin
         logic [167:0] e;
         logic [31:0] oc;
         e = VECS[v];
         run_one(e[167:136], e[135:104], e[103:72]);
         oc = (n_done == 1) ? (d_br ? 32'd0 : 32'd1)
            : (n_kill == 1) ? 32'd2 : (n_stop == 1) ? 32'd3 : 32'd15;
         chk($sformatf("R13/R4/R5 outcome vec %0d", v), oc, {28'd0, e[71:68]});
         chk($sformatf("R3 wake count vec %0d", v), n_wake, 32'd1);
         chk($sformatf("R2 fetch vec %0d", v), {first_addr[15:0], 16'(n_fetch)}, 32'h0100_0004);
         chk($sformatf("R8 flush vec %0d", v), n_flush, {28'd0, e[67:64]});
         chk($sformatf("R11/R7 word2 vec %0d", v), mem[8'h42], e[63:32]);
         chk($sformatf("R7 word3 vec %0d", v), mem[8'h43], e[31:0]);
         if (e[71:68] < 4'h2)
            chk($sformatf("R13 done dep vec %0d", v), d_dep, e[63:32]);
         if (e[71:68] == 4'h2)
            chk($sformatf("R5 kill with wake vec %0d", v), {31'd0, kill_wake}, 32'd1);
         if (e[71:68] == 4'h0 && e[167:164] < 4'h4)
            chk($sformatf("R6 xfer fields vec %0d", v),
                {x_addr[15:0], x_len[7:0], 3'd0, x_out, x_last, x_key},
                {e[119:104], e[143:136], 3'd0, !e[165], e[164], e[162:160]});
      end

      // R10/R12: stores with normalized size and lanes
      run_one(32'h4600_0001, 32'h211, 32'hAB00_0000);
      chk("R10 store byte", mem[8'h84], 32'h0000_AB00);
      chk("R13 store advances", {30'd0, 1'(n_done), d_br}, 32'd2);
      run_one(32'h4200_0002, 32'h215, 32'hBEEF_0000);
      chk("R12 key2 store as system / R10 half", mem[8'h85], 32'h0000_BEEF);
      run_one(32'h4600_0005, 32'h21B, 32'h0102_0304);
      chk("R9 store size4 aligned", mem[8'h86], 32'h0102_0304);
      chk("R8 store flush", n_flush, 32'd1);

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule